// File: doc/BRIEF.md
# Bordered Tile-Map Scroll Address Generator

This block turns a screen pixel position into the name-table byte address of the tile that covers that pixel, for one tile layer that scrolls smoothly on both axes. The map in memory is two tiles wider and two tiles taller than the visible window, so one ring of border tiles surrounds the centre. A signed fine scroll of up to seven pixels in either direction on each axis reads into that ring. The address never wraps around the map. When software wants to scroll further, it sets the fine scroll back to zero and moves the table contents by one tile.

On each requested fetch the block adds the clamped scroll to the pixel position. It finds the tile column and the tile row, counting the border as index 0. It forms `base + row*34 + col` and registers that address together with the 3-bit offset of the pixel inside the tile. A tall mode grows the visible window from 24 to 30 tile rows. The row stride stays the same in both modes. A request whose pixel row lies below the visible window produces no fetch.

Top module: `bscroll_addr_gen`

## Requirements
- R1: While `rst_n` is low, `fetch_valid`, `tile_addr`, `fine_x` and `fine_y` are all zero.
- R2: A request with `req_valid`=1 and `pix_y` inside the window, sampled on a rising edge, gives `fetch_valid`=1 after that edge and carries that request's results. The latency is exactly one cycle.
- R3: The tile column equals floor((`pix_x` + sx) / 8) + 1, and `fine_x` = (`pix_x` + sx) mod 8. Here sx is the clamped horizontal scroll.
- R4: The tile row equals floor((`pix_y` + sy) / 8) + 1, and `fine_y` = (`pix_y` + sy) mod 8. Here sy is the clamped vertical scroll.
- R5: `tile_addr` = (`base_addr` + row*34 + column) mod 2^14. Column 0 and row 0 are the left and top border tiles.
- R6: `scroll_x` and `scroll_y` are 4-bit two's complement values. The code 4'b1000 (-8) is treated as -7, so the scroll in use always lies in -7..+7.
- R7: The window is 192 pixel rows in normal mode (`tall_mode`=0) and 240 in tall mode (`tall_mode`=1). A request with `pix_y` at or beyond that limit gives `fetch_valid`=0 on the next cycle, and the outputs keep their previous values.
- R8: In tall mode the row stride stays 34. Pixel row 239 with a scroll of +7 reaches row 31, the last row of the 1088-byte table. In normal mode the last row is 25, inside an 884-byte table.
- R9: While `req_valid` is 0, `fetch_valid` is 0 on the next cycle and `tile_addr`, `fine_x` and `fine_y` hold their values.
- R10: At the corners, `pix_x`=255 with sx=+7 selects column 33 with `fine_x`=6, and `pix_x`=0 with sx=-7 selects column 0 with `fine_x`=1. The same holds on the vertical axis.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A fetch is requested for this cycle's pixel |
| pix_x | input | 8 | Screen pixel column, 0..255 |
| pix_y | input | 8 | Screen pixel row |
| scroll_x | input | 4 | Signed horizontal fine scroll |
| scroll_y | input | 4 | Signed vertical fine scroll |
| base_addr | input | 14 | Name-table base byte address |
| tall_mode | input | 1 | 1 selects the 30-row window |
| fetch_valid | output | 1 | Registered fetch strobe |
| tile_addr | output | 14 | Registered name-table byte address |
| fine_x | output | 3 | Registered pixel column inside the tile |
| fine_y | output | 3 | Registered pixel row inside the tile |

## Verification
A horizontal carry into a border column and a vertical carry into a border row can occur on the same fetch. Both then feed one sum, together with a base address that may wrap past 2^14. Directed requests place the pixel on all four corners of the window with a full positive or full negative scroll on both axes, and with a base near the top of the address space. A reference model in the bench, built from integer arithmetic, checks the address and both fine offsets at each of these requests. Random traffic then mixes both carries with out-of-window rows and idle cycles, and every output is compared on every clock.

// File: rtl/bscroll_pkg.sv
package bscroll_pkg;

  // log2 of the tile edge in pixels
  localparam int unsigned TILE_LG = 3;
  localparam int unsigned TILE_PX = 1 << TILE_LG;

  // window height selection
  typedef enum logic {
    WIN_NORMAL = 1'b0,
    WIN_TALL   = 1'b1
  } win_mode_e;

endpackage

// File: rtl/bscroll_clamp.sv
// Limits a signed fine-scroll code to the symmetric range -(2^(W-1)-1)..+(2^(W-1)-1).
module bscroll_clamp #(
  parameter int unsigned SCR_W = 4
) (
  input  logic [SCR_W-1:0] scr_in,
  output logic [SCR_W-1:0] scr_out
);

  localparam logic [SCR_W-1:0] MOST_NEG = {1'b1, {(SCR_W-1){1'b0}}};
  localparam logic [SCR_W-1:0] NEG_LIM  = MOST_NEG | {{(SCR_W-1){1'b0}}, 1'b1};

  always_comb begin
    if (scr_in == MOST_NEG) scr_out = NEG_LIM;
    else                    scr_out = scr_in;
  end

endmodule

// File: rtl/bscroll_axis.sv
// One axis: clamped scroll plus pixel position, shifted by one tile for the border.
module bscroll_axis
  import bscroll_pkg::*;
#(
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned SCR_W  = 4,
  parameter int unsigned IDX_W  = 6
) (
  input  logic [PIX_W-1:0]   pix,
  input  logic [SCR_W-1:0]   scroll,
  output logic [IDX_W-1:0]   tile_idx,
  output logic [TILE_LG-1:0] fine
);

  localparam int unsigned SUM_W = IDX_W + TILE_LG;

  logic [SCR_W-1:0] scr_c;
  logic [SUM_W-1:0] scr_ext;
  logic [SUM_W-1:0] pos_sum;

  bscroll_clamp #(.SCR_W(SCR_W)) u_clamp (
    .scr_in  (scroll),
    .scr_out (scr_c)
  );

  // The sum is pixel + one border tile + scroll, which is never negative.
  // It stays below 2^SUM_W, so modular addition gives the exact value.
  always_comb begin
    scr_ext  = {{(SUM_W-SCR_W){scr_c[SCR_W-1]}}, scr_c};
    pos_sum  = SUM_W'(pix) + SUM_W'(TILE_PX) + scr_ext;
    tile_idx = pos_sum[SUM_W-1:TILE_LG];
    fine     = pos_sum[TILE_LG-1:0];
  end

endmodule

// File: rtl/bscroll_stride_mul.sv
// row * STRIDE, chosen by structure of the constant.
module bscroll_stride_mul #(
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned ADDR_W = 14,
  parameter int unsigned STRIDE = 34
) (
  input  logic [IDX_W-1:0]  row,
  output logic [ADDR_W-1:0] row_off
);

  localparam int unsigned POW_K  = $clog2(STRIDE);
  localparam int unsigned PLUS_K = $clog2(STRIDE - 2);
  localparam bit IS_POW2  = ((STRIDE & (STRIDE - 1)) == 0);
  localparam bit IS_PLUS2 = (STRIDE > 2) && (((STRIDE - 2) & (STRIDE - 3)) == 0);

  logic [ADDR_W-1:0] row_w;
  assign row_w = ADDR_W'(row);

  generate
    if (IS_POW2) begin : g_shift
      assign row_off = row_w << POW_K;
    end else if (IS_PLUS2) begin : g_shift_add
      // stride = 2^K + 2: two shifted copies, no multiplier
      assign row_off = (row_w << PLUS_K) + (row_w << 1);
    end else begin : g_mult
      assign row_off = row_w * ADDR_W'(STRIDE);
    end
  endgenerate

endmodule

// File: rtl/bscroll_addr_gen.sv
module bscroll_addr_gen
  import bscroll_pkg::*;
#(
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned PIX_W         = 8,
  parameter int unsigned SCR_W         = 4,
  parameter int unsigned VIS_COLS      = 32,
  parameter int unsigned VIS_ROWS      = 24,
  parameter int unsigned VIS_ROWS_TALL = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [PIX_W-1:0]    pix_x,
  input  logic [PIX_W-1:0]    pix_y,
  input  logic [SCR_W-1:0]    scroll_x,
  input  logic [SCR_W-1:0]    scroll_y,
  input  logic [ADDR_W-1:0]   base_addr,
  input  logic                tall_mode,
  output logic                fetch_valid,
  output logic [ADDR_W-1:0]   tile_addr,
  output logic [TILE_LG-1:0]  fine_x,
  output logic [TILE_LG-1:0]  fine_y
);

  localparam int unsigned MAP_COLS   = VIS_COLS + 2;
  localparam int unsigned MAP_ROWS_T = VIS_ROWS_TALL + 2;
  localparam int unsigned IDX_W      = $clog2(((MAP_COLS > MAP_ROWS_T) ? MAP_COLS : MAP_ROWS_T));
  localparam int unsigned LIM_W      = PIX_W + 1;
  localparam logic [LIM_W-1:0] LIM_NORM = LIM_W'(VIS_ROWS * TILE_PX);
  localparam logic [LIM_W-1:0] LIM_TALL = LIM_W'(VIS_ROWS_TALL * TILE_PX);
  localparam int unsigned AX_N = 2;  // 0 = horizontal, 1 = vertical

  // per-axis lanes
  logic [PIX_W-1:0]   ax_pix    [AX_N];
  logic [SCR_W-1:0]   ax_scr    [AX_N];
  logic [IDX_W-1:0]   ax_idx    [AX_N];
  logic [TILE_LG-1:0] ax_fine   [AX_N];

  assign ax_pix[0] = pix_x;
  assign ax_pix[1] = pix_y;
  assign ax_scr[0] = scroll_x;
  assign ax_scr[1] = scroll_y;

  generate
    for (genvar a = 0; a < AX_N; a++) begin : g_axis
      bscroll_axis #(
        .PIX_W (PIX_W),
        .SCR_W (SCR_W),
        .IDX_W (IDX_W)
      ) u_axis (
        .pix      (ax_pix[a]),
        .scroll   (ax_scr[a]),
        .tile_idx (ax_idx[a]),
        .fine     (ax_fine[a])
      );
    end
  endgenerate

  logic [ADDR_W-1:0] row_off;

  bscroll_stride_mul #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .STRIDE (MAP_COLS)
  ) u_stride (
    .row     (ax_idx[1]),
    .row_off (row_off)
  );

  // ---------------- next-state logic ----------------
  win_mode_e          win_mode;
  logic [LIM_W-1:0]   row_lim;
  logic               in_win;
  logic               load_en;
  logic               valid_d;
  logic [ADDR_W-1:0]  addr_d;
  logic [TILE_LG-1:0] fx_d;
  logic [TILE_LG-1:0] fy_d;

  always_comb begin
    win_mode = win_mode_e'(tall_mode);
    row_lim  = (win_mode == WIN_TALL) ? LIM_TALL : LIM_NORM;
    in_win   = (LIM_W'(pix_y) < row_lim);
    load_en  = req_valid & in_win;
    valid_d  = load_en;
    addr_d   = base_addr + row_off + ADDR_W'(ax_idx[0]);
    fx_d     = ax_fine[0];
    fy_d     = ax_fine[1];
  end

  // ---------------- registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid <= 1'b0;
    end else begin
      fetch_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tile_addr <= '0;
      fine_x    <= '0;
      fine_y    <= '0;
    end else if (load_en) begin
      tile_addr <= addr_d;
      fine_x    <= fx_d;
      fine_y    <= fy_d;
    end
  end

endmodule

// File: rtl/bscroll_addr_gen_chk.sv
module bscroll_addr_gen_chk #(
  parameter int unsigned ADDR_W        = 14,
  parameter int unsigned PIX_W         = 8,
  parameter int unsigned SCR_W         = 4,
  parameter int unsigned VIS_COLS      = 32,
  parameter int unsigned VIS_ROWS      = 24,
  parameter int unsigned VIS_ROWS_TALL = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [PIX_W-1:0]  pix_x,
  input logic [PIX_W-1:0]  pix_y,
  input logic [SCR_W-1:0]  scroll_x,
  input logic [SCR_W-1:0]  scroll_y,
  input logic [ADDR_W-1:0] base_addr,
  input logic              tall_mode,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] tile_addr,
  input logic [2:0]        fine_x,
  input logic [2:0]        fine_y
);

  localparam int unsigned SZ_NORM = (VIS_COLS + 2) * (VIS_ROWS + 2);
  localparam int unsigned SZ_TALL = (VIS_COLS + 2) * (VIS_ROWS_TALL + 2);
  localparam logic [SCR_W-1:0] CODE_M8 = {1'b1, {(SCR_W-1){1'b0}}};

  logic in_win;
  assign in_win = tall_mode ? (int'(pix_y) < VIS_ROWS_TALL * 8)
                            : (int'(pix_y) < VIS_ROWS * 8);

  // R2: an in-window request produces a fetch one cycle later
  a_r2_fetch_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_win) |=> fetch_valid);

  // R7: rows below the window produce no fetch and leave the outputs alone
  a_r7_outside_window: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_win) |=> (!fetch_valid && $stable(tile_addr)
                                && $stable(fine_x) && $stable(fine_y)));

  // R9: idle cycles hold the outputs
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!fetch_valid && $stable(tile_addr)
                    && $stable(fine_x) && $stable(fine_y)));

  // R5, R8: the address stays within the table that starts at the base
  a_r8_inside_table: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> (int'(ADDR_W'(tile_addr - $past(base_addr)))
                     < ($past(tall_mode) ? SZ_TALL : SZ_NORM)));

  // R6: the code -8 acts as -7 on a tile-aligned column
  a_r6_clamp_minus8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_win && scroll_x == CODE_M8 && pix_x[2:0] == 3'd0)
      |=> (fine_x == 3'd1));

  // R10: left corner reads the left border column
  a_r10_left_border: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_win && pix_x == '0 && scroll_y == '0 && pix_y == '0
     && (scroll_x == CODE_M8 || scroll_x == {1'b1, {(SCR_W-2){1'b0}}, 1'b1}))
      |=> (fine_x == 3'd1 && tile_addr == ADDR_W'($past(base_addr) + ADDR_W'(VIS_COLS + 2))));

endmodule

bind bscroll_addr_gen bscroll_addr_gen_chk #(
  .ADDR_W        (ADDR_W),
  .PIX_W         (PIX_W),
  .SCR_W         (SCR_W),
  .VIS_COLS      (VIS_COLS),
  .VIS_ROWS      (VIS_ROWS),
  .VIS_ROWS_TALL (VIS_ROWS_TALL)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .pix_x       (pix_x),
  .pix_y       (pix_y),
  .scroll_x    (scroll_x),
  .scroll_y    (scroll_y),
  .base_addr   (base_addr),
  .tall_mode   (tall_mode),
  .fetch_valid (fetch_valid),
  .tile_addr   (tile_addr),
  .fine_x      (fine_x),
  .fine_y      (fine_y)
);

// File: tb/bscroll_addr_gen_tb.sv
module bscroll_addr_gen_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [7:0]  pix_x, pix_y;
  logic [3:0]  scroll_x, scroll_y;
  logic [13:0] base_addr;
  logic        tall_mode;
  logic        fetch_valid;
  logic [13:0] tile_addr;
  logic [2:0]  fine_x, fine_y;

  int n_cmp;
  int n_bad;
  bit done;

  // reference state
  int e_valid, e_addr, e_fx, e_fy;

  bscroll_addr_gen u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .pix_x       (pix_x),
    .pix_y       (pix_y),
    .scroll_x    (scroll_x),
    .scroll_y    (scroll_y),
    .base_addr   (base_addr),
    .tall_mode   (tall_mode),
    .fetch_valid (fetch_valid),
    .tile_addr   (tile_addr),
    .fine_x      (fine_x),
    .fine_y      (fine_y)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic int scr_val(input logic [3:0] c);
    int v;
    v = c[3] ? int'(c) - 16 : int'(c);
    if (v == -8) v = -7;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Advance one cycle with the given inputs and compare against the model.
  task automatic step(input bit v, input int x, input int y, input int sx_code,
                      input int sy_code, input int base, input bit tall, input string note);
    int ex, ey, col, row, lim;
    req_valid = v;
    pix_x     = 8'(x);
    pix_y     = 8'(y);
    scroll_x  = 4'(sx_code);
    scroll_y  = 4'(sy_code);
    base_addr = 14'(base);
    tall_mode = tall;
    @(negedge clk);
    lim = tall ? 240 : 192;
    if (v && y < lim) begin
      ex  = x + scr_val(scroll_x) + 8;
      ey  = y + scr_val(scroll_y) + 8;
      col = ex / 8;
      row = ey / 8;
      e_valid = 1;
      e_addr  = (base + row * 34 + col) % 16384;
      e_fx    = ex % 8;
      e_fy    = ey % 8;
    end else begin
      e_valid = 0;
    end
    check({note, " R2/R7/R9 fetch_valid"}, int'(fetch_valid), e_valid);
    check({note, " R5 tile_addr"}, int'(tile_addr), e_addr);
    check({note, " R3 fine_x"}, int'(fine_x), e_fx);
    check({note, " R4 fine_y"}, int'(fine_y), e_fy);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog expired: actual running expected finished");
      report();
    end
  end

  initial begin
    n_cmp = 0; n_bad = 0; done = 0;
    e_valid = 0; e_addr = 0; e_fx = 0; e_fy = 0;
    rst_n = 1'b0; req_valid = 1'b0; pix_x = '0; pix_y = '0;
    scroll_x = '0; scroll_y = '0; base_addr = '0; tall_mode = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 fetch_valid in reset", int'(fetch_valid), 0);
    check("R1 tile_addr in reset", int'(tile_addr), 0);
    check("R1 fine_x in reset", int'(fine_x), 0);
    check("R1 fine_y in reset", int'(fine_y), 0);
    rst_n = 1'b1;

    // R3 R4 R5: no scroll, plain positions
    step(1, 0, 0, 0, 0, 0, 0, "R5 origin");
    step(1, 17, 9, 0, 0, 100, 0, "R3 mid");
    step(1, 100, 50, 3, 5, 2000, 0, "R4 positive scroll");
    step(1, 100, 50, 13, 11, 2000, 0, "R4 negative scroll");
    // R10: corners on both axes in the same fetch
    step(1, 255, 191, 7, 7, 0, 0, "R10 bottom-right normal");
    step(1, 0, 0, 9, 9, 0, 0, "R10 top-left");
    step(1, 255, 0, 7, 9, 16380, 0, "R10 top-right base wrap");
    step(1, 0, 191, 9, 7, 16370, 0, "R10 bottom-left base wrap");
    // R6: code -8 acts as -7
    step(1, 0, 0, 8, 8, 40, 0, "R6 clamp both");
    step(1, 64, 64, 8, 0, 40, 0, "R6 clamp x");
    // R8: tall mode, stride 34
    step(1, 239 - 239 + 255, 239, 7, 7, 0, 1, "R8 tall last row");
    step(1, 10, 200, 0, 0, 500, 1, "R8 tall inside");
    // R7: outside the window
    step(1, 10, 200, 0, 0, 500, 0, "R7 normal below window");
    step(1, 10, 192, 0, 0, 500, 0, "R7 normal first outside row");
    step(1, 10, 240, 0, 0, 500, 1, "R7 tall first outside row");
    step(1, 10, 191, 0, 0, 500, 0, "R7 normal last inside row");
    // R9: idle holds
    step(0, 200, 30, 3, 3, 900, 0, "R9 idle");
    step(0, 1, 1, 0, 0, 0, 1, "R9 idle again");
    step(1, 8, 8, 15, 1, 321, 0, "R2 back to back a");
    step(1, 9, 9, 1, 15, 322, 1, "R2 back to back b");

    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 5) != 0, int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 16), int'($urandom % 16), int'($urandom % 16384),
           bit'($urandom % 2), "R5 random");
    end

    done = 1;
    report();
  end

endmodule